// File: doc/BRIEF.md
# Lane-Partitioned Compare and Reduce Unit

A purely combinational datapath slice that treats two 16-bit operands as a set of independent unsigned lanes and produces per-lane predicates. The operands are split into four 4-bit nibbles. A 3-bit break vector decides where the lane boundaries fall. The usual layouts are one 16-bit lane, two 8-bit lanes or four 4-bit lanes, but any break pattern gives a valid layout.

For every lane the unit returns six unsigned relations between the two operands: equal, not equal, less, less-or-equal, greater and greater-or-equal. It also returns four reductions of operand `a` alone: odd parity, any-bit-set, all-bits-set and a boolean that matches any-bit-set. Each result is a 4-bit vector. A lane's answer sits at the bit index of the lane's lowest nibble, so the packing of a result vector follows the lane layout in force.

Top module: `simd_cmp_reduce`

## Requirements
- R1: Break bit k (k = 0..2) set places a lane boundary between nibble k (bits 4k+3..4k) and nibble k+1. Common codes are 3'b000 for one 16-bit lane, 3'b010 for two 8-bit lanes and 3'b111 for four 4-bit lanes. Any of the 8 codes gives a valid layout.
- R2: eq_o holds 1 at a lane's lowest-nibble index when the lane slices of a_i and b_i are equal. ne_o holds 1 there when they differ.
- R3: lt_o and ge_o report a-slice < b-slice and a-slice >= b-slice, as unsigned numbers, at the lane's lowest-nibble index.
- R4: gt_o and le_o report a-slice > b-slice and a-slice <= b-slice, as unsigned numbers, at the lane's lowest-nibble index.
- R5: In all ten outputs, every bit whose nibble is not the lowest nibble of its lane is 0.
- R6: par_o is 1 at a lane's lowest-nibble index when the lane slice of a_i holds an odd number of ones.
- R7: any_o and bool_o are both 1 at a lane's lowest-nibble index when at least one bit of the lane slice of a_i is 1. The two are always equal.
- R8: all_o is 1 at a lane's lowest-nibble index only when every bit of the lane slice of a_i is 1.
- R9: The unit holds no state. Every output follows the present inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand, lane-partitioned |
| b_i | input | 16 | Second operand, lane-partitioned |
| brk_i | input | 3 | Lane boundary bits, one per internal nibble edge |
| eq_o | output | 4 | Per-lane equal |
| ne_o | output | 4 | Per-lane not equal |
| lt_o | output | 4 | Per-lane unsigned less |
| le_o | output | 4 | Per-lane unsigned less-or-equal |
| gt_o | output | 4 | Per-lane unsigned greater |
| ge_o | output | 4 | Per-lane unsigned greater-or-equal |
| par_o | output | 4 | Per-lane parity of a_i |
| any_o | output | 4 | Per-lane any bit of a_i set |
| all_o | output | 4 | Per-lane all bits of a_i set |
| bool_o | output | 4 | Per-lane boolean of a_i, same as any_o |

## Verification
There are no registers, so a fault in the nibble chains shows on the outputs as soon as the inputs settle. A wrong boundary decode or a broken carry between nibbles shows as a predicate at a non-lowest bit, or as a lane whose relation is decided by only its top or bottom nibble. Operands that differ only in a low nibble of a wide lane, or only across a boundary, expose these faults. The bench therefore sweeps all eight break codes, with edge operands, equal pairs, single-nibble differences and random values.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned NIB_N = 4;

  typedef enum logic [NIB_N-2:0] {
    LAYOUT_W16 = 3'b000,
    LAYOUT_W8  = 3'b010,
    LAYOUT_W4  = 3'b111
  } layout_e;
endpackage

// File: rtl/simd_lane_map.sv
module simd_lane_map #(
  parameter int unsigned NIB_N = 4
) (
  input  logic [NIB_N-2:0] brk_i,
  output logic [NIB_N-1:0] lead_o,
  output logic [NIB_N-1:0] top_o
);
  // lane starts above every break, ends below it
  assign lead_o = {brk_i, 1'b1};
  assign top_o  = {1'b1, brk_i};
endmodule

// File: rtl/simd_cmp_lane.sv
module simd_cmp_lane #(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned NIB_N = 4,
  localparam int unsigned DW = NIB_W * NIB_N
) (
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  input  logic [NIB_N-1:0] lead_i,
  input  logic [NIB_N-1:0] top_i,
  output logic [NIB_N-1:0] eq_o,
  output logic [NIB_N-1:0] gt_o,
  output logic [NIB_N-1:0] lt_o
);
  logic [NIB_N-1:0] nib_eq, nib_gt, nib_lt;

  for (genvar g = 0; g < NIB_N; g++) begin : g_nib
    assign nib_eq[g] = a_i[g*NIB_W +: NIB_W] == b_i[g*NIB_W +: NIB_W];
    assign nib_gt[g] = a_i[g*NIB_W +: NIB_W] >  b_i[g*NIB_W +: NIB_W];
    assign nib_lt[g] = a_i[g*NIB_W +: NIB_W] <  b_i[g*NIB_W +: NIB_W];
  end

  // scan from the top nibble down; the running result restarts at each lane top
  always_comb begin
    logic c_eq, c_gt, c_lt;
    c_eq = 1'b1;
    c_gt = 1'b0;
    c_lt = 1'b0;
    eq_o = '0;
    gt_o = '0;
    lt_o = '0;
    for (int i = NIB_N - 1; i >= 0; i--) begin
      if (top_i[i]) begin
        c_eq = nib_eq[i];
        c_gt = nib_gt[i];
        c_lt = nib_lt[i];
      end else begin
        c_gt = c_gt | (c_eq & nib_gt[i]);
        c_lt = c_lt | (c_eq & nib_lt[i]);
        c_eq = c_eq & nib_eq[i];
      end
      eq_o[i] = lead_i[i] & c_eq;
      gt_o[i] = lead_i[i] & c_gt;
      lt_o[i] = lead_i[i] & c_lt;
    end
  end
endmodule

// File: rtl/simd_reduce_lane.sv
module simd_reduce_lane #(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned NIB_N = 4,
  localparam int unsigned DW = NIB_W * NIB_N
) (
  input  logic [DW-1:0]    a_i,
  input  logic [NIB_N-1:0] lead_i,
  input  logic [NIB_N-1:0] top_i,
  output logic [NIB_N-1:0] par_o,
  output logic [NIB_N-1:0] any_o,
  output logic [NIB_N-1:0] all_o
);
  logic [NIB_N-1:0] nib_par, nib_or, nib_and;

  for (genvar g = 0; g < NIB_N; g++) begin : g_nib
    assign nib_par[g] = ^a_i[g*NIB_W +: NIB_W];
    assign nib_or[g]  = |a_i[g*NIB_W +: NIB_W];
    assign nib_and[g] = &a_i[g*NIB_W +: NIB_W];
  end

  always_comb begin
    logic c_par, c_or, c_and;
    c_par = 1'b0;
    c_or  = 1'b0;
    c_and = 1'b1;
    par_o = '0;
    any_o = '0;
    all_o = '0;
    for (int i = NIB_N - 1; i >= 0; i--) begin
      if (top_i[i]) begin
        c_par = nib_par[i];
        c_or  = nib_or[i];
        c_and = nib_and[i];
      end else begin
        c_par = c_par ^ nib_par[i];
        c_or  = c_or | nib_or[i];
        c_and = c_and & nib_and[i];
      end
      par_o[i] = lead_i[i] & c_par;
      any_o[i] = lead_i[i] & c_or;
      all_o[i] = lead_i[i] & c_and;
    end
  end
endmodule

// File: rtl/simd_cmp_reduce.sv
module simd_cmp_reduce
  import simd_cmp_pkg::*;
(
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  input  logic [2:0]  brk_i,
  output logic [3:0]  eq_o,
  output logic [3:0]  ne_o,
  output logic [3:0]  lt_o,
  output logic [3:0]  le_o,
  output logic [3:0]  gt_o,
  output logic [3:0]  ge_o,
  output logic [3:0]  par_o,
  output logic [3:0]  any_o,
  output logic [3:0]  all_o,
  output logic [3:0]  bool_o
);
  logic [NIB_N-1:0] lead, top;
  logic [NIB_N-1:0] c_eq, c_gt, c_lt;

  simd_lane_map #(.NIB_N(NIB_N)) i_map (
    .brk_i  (brk_i),
    .lead_o (lead),
    .top_o  (top)
  );

  simd_cmp_lane #(.NIB_W(NIB_W), .NIB_N(NIB_N)) i_cmp (
    .a_i    (a_i),
    .b_i    (b_i),
    .lead_i (lead),
    .top_i  (top),
    .eq_o   (c_eq),
    .gt_o   (c_gt),
    .lt_o   (c_lt)
  );

  simd_reduce_lane #(.NIB_W(NIB_W), .NIB_N(NIB_N)) i_red (
    .a_i    (a_i),
    .lead_i (lead),
    .top_i  (top),
    .par_o  (par_o),
    .any_o  (any_o),
    .all_o  (all_o)
  );

  assign eq_o   = c_eq;
  assign ne_o   = lead & ~c_eq;
  assign gt_o   = c_gt;
  assign lt_o   = c_lt;
  assign le_o   = c_lt | c_eq;
  assign ge_o   = c_gt | c_eq;
  assign bool_o = any_o;

  always_comb begin
    // R5
    lead_only_chk: assert (((c_eq | c_gt | c_lt | par_o | any_o | all_o) & ~lead) == '0);
    // R3
    lt_gt_excl_chk: assert ((c_lt & c_gt) == '0);
    // R2
    eq_excl_chk: assert ((c_eq & (c_lt | c_gt)) == '0);
    // R4
    order_total_chk: assert ((c_eq | c_lt | c_gt) == lead);
    // R8
    all_any_chk: assert ((all_o & ~any_o) == '0);
    // R6
    all_even_par_chk: assert ((all_o & par_o) == '0);
  end
endmodule

// File: tb/test_simd_cmp_reduce.sv
module test_simd_cmp_reduce;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] a, b;
  logic [2:0]  brk;
  logic [3:0]  eq, ne, lt, le, gt, ge, par, any_v, all_v, bool_v;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  simd_cmp_reduce i_simd_cmp_reduce (
    .a_i(a), .b_i(b), .brk_i(brk),
    .eq_o(eq), .ne_o(ne), .lt_o(lt), .le_o(le), .gt_o(gt), .ge_o(ge),
    .par_o(par), .any_o(any_v), .all_o(all_v), .bool_o(bool_v)
  );

  task automatic chk(input string req, input string nm, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s a=%h b=%h brk=%b act=%b exp=%b", req, nm, a, b, brk, act, exp);
    end
  endtask

  task automatic run_vec(input logic [15:0] va, input logic [15:0] vb);
    logic [3:0] e_eq, e_lt, e_gt, e_par, e_any, e_all;
    int lo;
    @(posedge clk);
    #1;
    a = va;
    b = vb;
    #1;
    e_eq = '0; e_lt = '0; e_gt = '0; e_par = '0; e_any = '0; e_all = '0;
    lo = 0;
    // R1: lane ends at nibble i when i==3 or brk[i]
    for (int i = 0; i < 4; i++) begin
      if (i == 3 || brk[i]) begin
        int w;
        int unsigned msk, sa, sb;
        w = (i - lo + 1) * 4;
        msk = (32'd1 << w) - 1;
        sa = (int'(va) >> (lo * 4)) & msk;
        sb = (int'(vb) >> (lo * 4)) & msk;
        e_eq[lo]  = (sa == sb);
        e_lt[lo]  = (sa < sb);
        e_gt[lo]  = (sa > sb);
        e_par[lo] = ^sa;
        e_any[lo] = (sa != 0);
        e_all[lo] = (sa == msk);
        lo = i + 1;
      end
    end
    // R5: non-lead bits are zero in every expected vector by construction of the model
    chk("R2", "eq", eq, e_eq);
    chk("R2", "ne", ne, ~e_eq & {brk, 1'b1});
    chk("R3", "lt", lt, e_lt);
    chk("R3", "ge", ge, e_gt | e_eq);
    chk("R4", "gt", gt, e_gt);
    chk("R4", "le", le, e_lt | e_eq);
    chk("R6", "par", par, e_par);
    chk("R7", "any", any_v, e_any);
    chk("R7", "bool", bool_v, e_any);
    chk("R8", "all", all_v, e_all);
    chk("R5", "nonlead", (eq | ne | lt | le | gt | ge | par | any_v | all_v | bool_v) & ~{brk, 1'b1}, 4'b0000);
  endtask

  initial begin
    int seed_dummy;
    a = '0; b = '0; brk = '0;
    seed_dummy = $urandom(7);
    // R9: outputs follow inputs with no clock edge
    #1;
    chk("R9", "eq_idle", eq, 4'b0001);
    a = 16'h0001;
    #1;
    chk("R9", "gt_comb", gt, 4'b0001);
    for (int m = 0; m < 8; m++) begin
      brk = 3'(m);
      run_vec(16'h0000, 16'h0000);
      run_vec(16'hFFFF, 16'hFFFF);
      run_vec(16'h0000, 16'hFFFF);
      run_vec(16'hFFFF, 16'h0000);
      run_vec(16'h1234, 16'h1234);
      run_vec(16'h8000, 16'h7FFF);
      run_vec(16'h00FF, 16'h0F0F);
      run_vec(16'hF0F0, 16'hF0F1);
      run_vec(16'h0FFF, 16'hF000);
      // single-nibble differences at every position and both directions
      for (int n = 0; n < 4; n++) begin
        run_vec(16'h5555 ^ (16'h0001 << (4 * n)), 16'h5555);
        run_vec(16'h5555, 16'h5555 ^ (16'h0008 << (4 * n)));
        run_vec(16'hFFFF ^ (16'h0001 << (4 * n)), 16'h0000);
      end
      for (int r = 0; r < 120; r++) begin
        logic [15:0] ra;
        ra = 16'($urandom);
        run_vec(ra, (r % 4 == 0) ? ra : 16'($urandom));
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule